// File: doc/BRIEF.md
# Reverse-Order Suffix Insertion Sorter

This block produces the Burrows-Wheeler transform of one block of bytes without comparison sorting. The producer streams the block in reverse, from the final byte back to the first, one byte per valid/ready handshake. An implicit end marker closes the string and ranks above every byte value. Each node of a doubly linked list represents one suffix, and the list is kept in lexicographic order. When a byte `c` arrives, the block writes `c` into the node of the suffix inserted just before as that node's preceding symbol. It then walks forward from that node and looks for the first node whose stored preceding symbol equals `c`. On a hit, the new suffix goes immediately in front of the suffix that begins one position earlier than the hit node.

On a miss, a per-symbol table of largest suffixes supplies the insertion point. This is the newest largest suffix for `c` if `c` has been seen, otherwise the one for the greatest smaller symbol already seen. If no such symbol exists, the new node becomes the list head. An insertion takes two cycles: one writes the new node, the other rewires its neighbours.

Once the closing byte is taken, the list is walked from its head. Each node's stored preceding symbol is emitted as one byte of the last column of the sorted rotation matrix. When the stream ends, the rank of the unrotated string is presented. The block then clears itself and accepts the next block.

Top module: `bwt_sorter`

## Requirements
- R1: After reset, `inReady` is high and `outValid` is low.
- R2: A block of L bytes produces exactly L+1 consecutive cycles with `outValid` high. `outLast` is high only on the final one.
- R3: The sequence on `outSym` equals the last column of the sorted rotations of the string x1..xL followed by the end marker, with the end marker ranking above all bytes. The end marker is encoded as 2^SYM_W (bit SYM_W set, lower bits zero). Real bytes appear zero-extended with bit SYM_W clear.
- R4: While `outLast` is high, `outPrimary` holds the zero-based rank, among the sorted rotations, of the rotation that begins with x1.
- R5: Each output stream carries the end-marker code exactly once.
- R6: `inReady` goes low on the cycle after the closing byte is accepted. It stays low for the whole output stream and is high again on the cycle after `outLast`.
- R7: When MAX_LEN bytes have been accepted without `inLast`, the MAX_LEN-th byte closes the block as if `inLast` had been set.
- R8: A block that follows another without a reset is transformed exactly as it would be after a reset.
- R9: `inValid`, `inSym` and `inLast` have no effect while `inReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte present |
| inSym | input | SYM_W | Input byte, supplied last-to-first |
| inLast | input | 1 | Marks the first byte of the string (the final one streamed) |
| inReady | output | 1 | Block can take a byte this cycle |
| outValid | output | 1 | Output byte present |
| outSym | output | SYM_W+1 | Last-column symbol; 2^SYM_W means end marker |
| outLast | output | 1 | Final symbol of the stream |
| outPrimary | output | clog2(MAX_LEN+1) | Rank of the unrotated string, valid with outLast |

## Verification
The hardest path to reach is a scan that crosses several nodes and then hits, followed by a splice ahead of the current head. Strongly repetitive data such as a single repeated byte or a two-letter alphabet drives the block down that path, and the stimulus uses both on purpose. Random blocks over small alphabets exercise both the seen-symbol and the smaller-symbol fallbacks. A full-range byte block and a maximum-length block without `inLast` cover the extremes of the symbol and length ranges. Noise blocks drive random handshake values whenever the block is busy.

// File: rtl/bwt_sort_pkg.sv
package bwt_sort_pkg;
  typedef enum logic [2:0] {
    ST_ACCEPT,
    ST_SCAN,
    ST_LINK_NEW,
    ST_LINK_NBR,
    ST_WALK
  } stateT;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic take;
    logic step;
    logic linkNew;
    logic linkNbr;
    logic walkStep;
  } ctrlT;
endpackage

// File: rtl/bwt_sort_dict.sv
module bwt_sort_dict #(
  parameter int SYM_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wrEn,
  input  logic [SYM_W-1:0]  wrSym,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SYM_W-1:0]  lkSym,
  output logic              found,
  output logic [ADDR_W-1:0] foundAddr
);
  localparam int NSYM = 1 << SYM_W;

  logic [NSYM-1:0]   seenBits;
  logic [ADDR_W-1:0] largestMem [NSYM];

  always_ff @(posedge clk) begin
    if (!rstN || clear) seenBits <= '0;
    else if (wrEn)      seenBits[wrSym] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) largestMem[wrSym] <= wrAddr;
  end

  // greatest seen symbol not above the lookup symbol; equal wins when seen
  always_comb begin
    found     = 1'b0;
    foundAddr = '0;
    for (int g = 0; g < NSYM; g++) begin
      if (seenBits[g] && g <= int'(lkSym)) begin
        found     = 1'b1;
        foundAddr = largestMem[g];
      end
    end
  end
endmodule

// File: rtl/bwt_sort_ctrl.sv
module bwt_sort_ctrl
  import bwt_sort_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic firstSym,
  input  logic scanHit,
  input  logic scanEnd,
  input  logic blockDone,
  input  logic walkEnd,
  output ctrlT ctrl,
  output logic inReady,
  output logic outValid
);
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_ACCEPT:   if (inValid) stateNext = firstSym ? ST_LINK_NEW : ST_SCAN;
      ST_SCAN:     if (scanHit || scanEnd) stateNext = ST_LINK_NEW;
      ST_LINK_NEW: stateNext = ST_LINK_NBR;
      ST_LINK_NBR: stateNext = blockDone ? ST_WALK : ST_ACCEPT;
      ST_WALK:     if (walkEnd) stateNext = ST_ACCEPT;
      default:     stateNext = ST_ACCEPT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACCEPT;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.take     = (state == ST_ACCEPT) && inValid;
    ctrl.step     = (state == ST_SCAN);
    ctrl.linkNew  = (state == ST_LINK_NEW);
    ctrl.linkNbr  = (state == ST_LINK_NBR);
    ctrl.walkStep = (state == ST_WALK);
  end

  assign inReady  = (state == ST_ACCEPT);
  assign outValid = (state == ST_WALK);
endmodule

// File: rtl/bwt_sort_datapath.sv
module bwt_sort_datapath
  import bwt_sort_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int MAX_LEN = 64,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [SYM_W-1:0]  inSym,
  input  logic              inLast,
  output logic              firstSym,
  output logic              scanHit,
  output logic              scanEnd,
  output logic              blockDone,
  output logic              walkEnd,
  output logic [SYM_W:0]    outSym,
  output logic              outLast,
  output logic [ADDR_W-1:0] outPrimary
);
  localparam int NODES = MAX_LEN + 1;
  localparam logic [SYM_W:0]    SENT_CODE = {1'b1, {SYM_W{1'b0}}};
  localparam logic [ADDR_W-1:0] CAP       = ADDR_W'(MAX_LEN);

  // list storage; node 0 is the end-marker suffix, node k the k-th byte taken
  logic [ADDR_W-1:0] nextMem [NODES];
  logic [ADDR_W-1:0] prevMem [NODES];
  logic [SYM_W:0]    symMem  [NODES];

  logic [ADDR_W-1:0] curAddr, newAddr, scanPtr, hitNode, head;
  logic [ADDR_W-1:0] linkP, linkS, pReg, sReg;
  logic [ADDR_W-1:0] primAddr, walkPtr, walkRank, primRank;
  logic [SYM_W-1:0]  symReg;
  logic              hitReg, lastReg, linkPValid, pValidReg;
  logic              dictFound;
  logic [ADDR_W-1:0] dictAddr;

  assign newAddr   = curAddr + 1'b1;
  assign firstSym  = (curAddr == '0);
  assign scanHit   = (symMem[scanPtr] == {1'b0, symReg});
  assign scanEnd   = (scanPtr == '0);
  assign blockDone = lastReg;
  assign walkEnd   = (walkPtr == '0);
  assign outSym    = symMem[walkPtr];
  assign outLast   = ctrl.walkStep && walkEnd;
  assign outPrimary = (walkPtr == primAddr) ? walkRank : primRank;

  bwt_sort_dict #(.SYM_W(SYM_W), .ADDR_W(ADDR_W)) dict_i (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (outLast),
    .wrEn     (ctrl.linkNew && !hitReg),
    .wrSym    (symReg),
    .wrAddr   (newAddr),
    .lkSym    (symReg),
    .found    (dictFound),
    .foundAddr(dictAddr)
  );

  // neighbours of the new node
  always_comb begin
    if (hitReg) begin
      linkPValid = (hitNode != head);
      linkP      = prevMem[hitNode];
      linkS      = hitNode;
    end else begin
      linkPValid = dictFound;
      linkP      = dictAddr;
      linkS      = dictFound ? nextMem[dictAddr] : head;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0; head <= '0; scanPtr <= '0; hitNode <= '0; hitReg <= 1'b0;
      lastReg <= 1'b0; symReg <= '0; pReg <= '0; sReg <= '0; pValidReg <= 1'b0;
      primAddr <= '0; walkPtr <= '0; walkRank <= '0; primRank <= '0;
    end else begin
      if (ctrl.take) begin
        symReg  <= inSym;
        lastReg <= inLast || (newAddr == CAP);
        scanPtr <= nextMem[curAddr];
        hitReg  <= 1'b0;
      end
      if (ctrl.step) begin
        if (scanHit) begin
          hitReg  <= 1'b1;
          hitNode <= scanPtr + 1'b1;
        end else begin
          scanPtr <= nextMem[scanPtr];
        end
      end
      if (ctrl.linkNew) begin
        pReg      <= linkP;
        sReg      <= linkS;
        pValidReg <= linkPValid;
      end
      if (ctrl.linkNbr) begin
        if (!pValidReg) head <= newAddr;
        curAddr <= newAddr;
        if (lastReg) begin
          primAddr <= newAddr;
          walkPtr  <= pValidReg ? head : newAddr;
          walkRank <= '0;
        end
      end
      if (ctrl.walkStep) begin
        walkPtr  <= nextMem[walkPtr];
        walkRank <= walkRank + 1'b1;
        if (walkPtr == primAddr) primRank <= walkRank;
        if (walkEnd) begin
          curAddr <= '0;
          head    <= '0;
          lastReg <= 1'b0;
        end
      end
    end
  end

  // list memory: at most one write per array per cycle
  always_ff @(posedge clk) begin
    if (ctrl.take) symMem[curAddr] <= {1'b0, inSym};
    if (ctrl.linkNbr && lastReg) symMem[newAddr] <= SENT_CODE;
    if (ctrl.linkNew) begin
      nextMem[newAddr] <= linkS;
      prevMem[newAddr] <= linkP;
    end
    if (ctrl.linkNbr) begin
      if (pValidReg) nextMem[pReg] <= newAddr;
      prevMem[sReg] <= newAddr;
    end
  end

  // end-marker occurrences seen so far in the current stream
  logic [1:0] sentCnt;
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.linkNbr) sentCnt <= '0;
    else if (ctrl.walkStep && outSym[SYM_W] && sentCnt != 2'd3) sentCnt <= sentCnt + 1'b1;
  end

  p_marker_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.walkStep && outSym[SYM_W]) |-> (outSym[SYM_W-1:0] == '0));

  p_one_marker_r5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> ((sentCnt == 2'd1 && !outSym[SYM_W]) || (sentCnt == 2'd0 && outSym[SYM_W])));

  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    curAddr <= CAP);

  p_primary_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outPrimary < walkRank));
endmodule

// File: rtl/bwt_sorter.sv
module bwt_sorter
  import bwt_sort_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int MAX_LEN = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [SYM_W-1:0]               inSym,
  input  logic                           inLast,
  output logic                           inReady,
  output logic                           outValid,
  output logic [SYM_W:0]                 outSym,
  output logic                           outLast,
  output logic [$clog2(MAX_LEN+1)-1:0]   outPrimary
);
  localparam int ADDR_W = $clog2(MAX_LEN + 1);

  ctrlT ctrl;
  logic firstSym, scanHit, scanEnd, blockDone, walkEnd;

  bwt_sort_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .firstSym(firstSym), .scanHit(scanHit), .scanEnd(scanEnd),
    .blockDone(blockDone), .walkEnd(walkEnd),
    .ctrl(ctrl), .inReady(inReady), .outValid(outValid)
  );

  bwt_sort_datapath #(.SYM_W(SYM_W), .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inSym(inSym), .inLast(inLast),
    .firstSym(firstSym), .scanHit(scanHit), .scanEnd(scanEnd),
    .blockDone(blockDone), .walkEnd(walkEnd),
    .outSym(outSym), .outLast(outLast), .outPrimary(outPrimary)
  );

  p_stream_closes_r2: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

  p_ready_returns_r6: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> inReady);

  p_busy_while_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  p_close_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);
endmodule

// File: tb/bwt_sorter_tb_top.sv
module bwt_sorter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_W      = 8;
  localparam int MAX_LEN    = 12;
  localparam int AW         = $clog2(MAX_LEN + 1);
  localparam int MARK       = 1 << SYM_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [SYM_W-1:0] inSym = '0;
  logic inLast = 1'b0;
  logic inReady, outValid, outLast;
  logic [SYM_W:0] outSym;
  logic [AW-1:0] outPrimary;

  int checks = 0;
  int errors = 0;
  int blk [MAX_LEN];
  int blen;
  int expSym [MAX_LEN+1];
  int expPrim;
  int gotSym [MAX_LEN+2];
  int gotCnt, gotPrim, readyLeaks;

  bwt_sorter #(.SYM_W(SYM_W), .MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSym(inSym), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outSym(outSym), .outLast(outLast),
    .outPrimary(outPrimary)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int symAt(int k, int n);
    return (k < n - 1) ? blk[k] : MARK;
  endfunction

  function automatic bit rotLess(int a, int b, int n);
    for (int t = 0; t < n; t++) begin
      int ca = symAt((a + t) % n, n);
      int cb = symAt((b + t) % n, n);
      if (ca != cb) return ca < cb;
    end
    return 1'b0;
  endfunction

  // naive rotation sort of x1..xL plus end marker
  function automatic void refBwt();
    int n = blen + 1;
    for (int r = 0; r < n; r++) begin
      int rank = 0;
      for (int q = 0; q < n; q++) if (rotLess(q, r, n)) rank++;
      expSym[rank] = symAt((r + n - 1) % n, n);
      if (r == 0) expPrim = rank;
    end
  endfunction

  task automatic runBlock(input string tag, input bit useLast, input bit noise);
    int firstBad, marks;
    refBwt();
    for (int k = blen - 1; k >= 0; k--) begin
      @(negedge clk);
      inValid = 1'b1;
      inSym   = SYM_W'(blk[k]);
      inLast  = useLast && (k == 0);
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = noise; inSym = SYM_W'($urandom); inLast = noise;
    gotCnt = 0; readyLeaks = 0; gotPrim = -1;
    forever begin
      if (inReady) readyLeaks++;
      if (outValid) begin
        if (gotCnt < MAX_LEN + 2) gotSym[gotCnt] = int'(outSym);
        gotCnt++;
        if (outLast) begin
          gotPrim = int'(outPrimary);
          inValid = 1'b0; inLast = 1'b0;
          break;
        end
      end
      if (noise) begin
        inValid = 1'($urandom); inSym = SYM_W'($urandom); inLast = 1'($urandom);
      end
      @(negedge clk);
    end
    check(gotCnt == blen + 1, {"R2 length ", tag}, gotCnt, blen + 1);
    firstBad = -1; marks = 0;
    for (int k = 0; k < blen + 1 && k < gotCnt; k++) begin
      if (gotSym[k] == MARK) marks++;
      if (firstBad < 0 && gotSym[k] != expSym[k]) firstBad = k;
    end
    if (firstBad >= 0)
      check(1'b0, {"R3 symbols ", tag}, gotSym[firstBad], expSym[firstBad]);
    else
      check(1'b1, {"R3 symbols ", tag}, 0, 0);
    check(gotPrim == expPrim, {"R4 primary ", tag}, gotPrim, expPrim);
    check(marks == 1, {"R5 marker count ", tag}, marks, 1);
    check(readyLeaks == 0, {"R6 ready low while busy ", tag}, readyLeaks, 0);
    @(negedge clk);
    check(inReady == 1'b1, {"R6 ready after stream ", tag}, int'(inReady), 1);
  endtask

  function automatic void loadStr(string s);
    blen = s.len();
    for (int k = 0; k < blen; k++) blk[k] = int'(s[k]);
  endfunction

  initial begin
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R1 no output after reset", int'(outValid), 0);

    loadStr("BANANA");
    runBlock("banana", 1'b1, 1'b0);
    check(expPrim == 3 && expSym[3] == MARK && expSym[0] == 66, "R3 banana model", expPrim, 3);

    loadStr("Z");
    runBlock("single", 1'b1, 1'b0);
    loadStr("AAAAAAAAAA");
    runBlock("repeat", 1'b1, 1'b0);
    loadStr("ABABABABAB");
    runBlock("pairs", 1'b1, 1'b0);

    blen = 8;
    for (int k = 0; k < 8; k++) blk[k] = k + 1;
    runBlock("ascending", 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) blk[k] = 250 - k;
    runBlock("descending", 1'b1, 1'b0);
    blen = 6;
    blk[0] = 0; blk[1] = 255; blk[2] = 0; blk[3] = 255; blk[4] = 255; blk[5] = 0;
    runBlock("extremes", 1'b1, 1'b0);

    // R7: full-length block with inLast never raised
    blen = MAX_LEN;
    for (int k = 0; k < MAX_LEN; k++) blk[k] = 65 + int'($urandom % 3);
    runBlock("R7 cap", 1'b0, 1'b0);
    // R8: immediately reused
    loadStr("MISSISSIPPI");
    runBlock("R8 back-to-back", 1'b1, 1'b0);
    // R9: noise on the input while busy
    loadStr("CABBAGEBAG");
    runBlock("R9 noise", 1'b1, 1'b1);

    for (int b = 0; b < 24; b++) begin
      int alpha = (b % 3 == 0) ? 256 : 2 + int'($urandom % 3);
      blen = 1 + int'($urandom % MAX_LEN);
      for (int k = 0; k < blen; k++)
        blk[k] = (alpha == 256) ? int'($urandom % 256) : 97 + int'($urandom % alpha);
      runBlock($sformatf("R8 random %0d", b), 1'b1, 1'($urandom));
    end
    report();
  end
endmodule